// File: doc/BRIEF.md
# Complement-Write Fault Masking Memory Wrapper

This block sits between a host and a word-organised storage array whose cells may hold known stuck values. For every write it decides whether to store the host word as it is or its bitwise complement. The aim is that each known faulty cell receives exactly the value it is stuck at, so the fault never shows. The array is one bit wider than the data word. That extra column holds a per-row inversion flag. On a read, the flag is XORed back into the data before the word reaches the host.

The known faults come from a small descriptor table. A test and repair controller writes it through a configuration port. Each entry has a valid bit, the bit position of the faulty column and the stuck value. Each entry also has a scope flag: it either covers every row or only the row address it carries. Faults that masking cannot cover are left to a separate spare-replacement scheme. Two matching entries in one row may ask for opposite choices. In that case the word is stored uninverted and a sticky error flag is raised.

A sequencer with four states runs each access:
- `S_IDLE` accepts a request. The transition *accept-write* goes to `S_WCOMMIT`, and *accept-read* goes to `S_RISSUE`. Neither is taken while configuration is enabled.
- `S_WCOMMIT` drives the array write and returns to `S_IDLE` (*commit-done*).
- `S_RISSUE` drives the array read and moves to `S_RXOR` (*data-wait*).
- `S_RXOR` registers the corrected word and returns to `S_IDLE` (*read-done*).

Top module: `cwm_wrapper`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `err_unmask`, `arr_we` and `arr_re` are 0. Every descriptor entry is invalid.
- R2: A write to a row that no valid entry matches stores the host word unchanged, with the inversion flag (array bit `DATA_W`) equal to 0.
- R3: A write is stored unchanged with flag 0 when every matching entry already finds its stuck value at its column in the host word.
- R4: A write is stored as the bitwise complement with flag 1 when every matching entry finds the opposite of its stuck value at its column. Each such faulty column then receives its stuck value.
- R5: A read returns array bits `DATA_W-1:0` XORed with the replicated flag bit. A row written under R3 or R4 therefore reads back as the original host word.
- R6: An entry with the all-rows flag set matches every row address. An entry with the flag clear matches only the row equal to its stored row field.
- R7: If matching entries need opposite choices, the word is stored unchanged with flag 0 and `err_unmask` rises. `err_unmask` then stays 1 until reset.
- R8: An accepted write drives `arr_we` in the next cycle only. An accepted read drives `arr_re` in the next cycle, and `rsp_valid` pulses two cycles after that.
- R9: While `cfg_en` is 1, `req_ready` is 0 and no request is accepted. A table load with `cfg_we` high and `cfg_en` low changes nothing.
- R10: An entry loaded with its valid bit at 0 takes no part in the write decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Configuration window; stalls host accesses |
| cfg_we | input | 1 | Load the entry selected by `cfg_idx` |
| cfg_idx | input | IDX_W | Entry index |
| cfg_valid | input | 1 | Valid bit of the loaded entry |
| cfg_all_rows | input | 1 | Entry applies to all rows |
| cfg_row | input | ADDR_W | Row of the loaded entry |
| cfg_col | input | COL_W | Faulty bit position |
| cfg_stuck | input | 1 | Stuck value of the faulty cell |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Row address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Corrected read data |
| err_unmask | output | 1 | Sticky conflicting-mask flag |
| arr_we | output | 1 | Array write strobe |
| arr_re | output | 1 | Array read strobe (data next cycle) |
| arr_addr | output | ADDR_W | Array row address |
| arr_wdata | output | DATA_W+1 | Array word; top bit is the inversion flag |
| arr_rdata | input | DATA_W+1 | Array read word |

## Verification
The bench builds the wrapper with 16-bit words, 16 rows and 4 descriptor entries. With these values it can place a row-scoped fault and an all-rows fault in the same row. That makes the keep, invert and conflicting cases reachable with plain hex words. Its array model forces the loaded stuck values into the stored words. A read-back therefore shows a masking failure directly. Entry loads that are invalid or made outside the configuration window are each chosen so that they would flip a later write's decision if they took effect.

// File: rtl/cwm_pkg.sv
package cwm_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_WCOMMIT,
        S_RISSUE,
        S_RXOR
    } cwm_state_e;
endpackage

// File: rtl/cwm_fault_table.sv
module cwm_fault_table #(
    parameter int N_ENT  = 4,
    parameter int ADDR_W = 4,
    parameter int COL_W  = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic              cfg_all_rows,
    input  logic [ADDR_W-1:0] cfg_row,
    input  logic [COL_W-1:0]  cfg_col,
    input  logic              cfg_stuck,
    output logic              ent_valid [N_ENT],
    output logic              ent_all   [N_ENT],
    output logic [ADDR_W-1:0] ent_row   [N_ENT],
    output logic [COL_W-1:0]  ent_col   [N_ENT],
    output logic              ent_stuck [N_ENT]
);
    logic load;
    assign load = cfg_en && cfg_we;

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_valid[i] <= 1'b0;
                ent_all[i]   <= 1'b0;
                ent_row[i]   <= '0;
                ent_col[i]   <= '0;
                ent_stuck[i] <= 1'b0;
            end else if (load && (cfg_idx == IDX_W'(i))) begin
                ent_valid[i] <= cfg_valid;
                ent_all[i]   <= cfg_all_rows;
                ent_row[i]   <= cfg_row;
                ent_col[i]   <= cfg_col;
                ent_stuck[i] <= cfg_stuck;
            end
        end
    end
endmodule

// File: rtl/cwm_inv_decide.sv
module cwm_inv_decide #(
    parameter int N_ENT  = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int COL_W  = 4
) (
    input  logic              ent_valid [N_ENT],
    input  logic              ent_all   [N_ENT],
    input  logic [ADDR_W-1:0] ent_row   [N_ENT],
    input  logic [COL_W-1:0]  ent_col   [N_ENT],
    input  logic              ent_stuck [N_ENT],
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              invert,
    output logic              conflict
);
    logic [N_ENT-1:0] want_inv;
    logic [N_ENT-1:0] want_keep;

    for (genvar i = 0; i < N_ENT; i++) begin : g_match
        logic hit;
        logic col_ok;
        logic dbit;
        assign col_ok = (int'(ent_col[i]) < DATA_W);
        assign hit    = ent_valid[i] && col_ok && (ent_all[i] || (ent_row[i] == addr));
        assign dbit   = wdata[ent_col[i]];
        assign want_inv[i]  = hit && (dbit != ent_stuck[i]);
        assign want_keep[i] = hit && (dbit == ent_stuck[i]);
    end

    always_comb begin
        conflict = (|want_inv) && (|want_keep);
        invert   = (|want_inv) && !conflict;
    end
endmodule

// File: rtl/cwm_seq.sv
module cwm_seq
    import cwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_en,
    input  logic       req_valid,
    input  logic       req_write,
    output cwm_state_e state,
    output logic       req_ready,
    output logic       acc_wr,
    output logic       acc_rd
);
    cwm_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (acc_wr)      state_nx = S_WCOMMIT;
                else if (acc_rd) state_nx = S_RISSUE;
            end
            S_WCOMMIT: state_nx = S_IDLE;
            S_RISSUE:  state_nx = S_RXOR;
            S_RXOR:    state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state == S_IDLE) && !cfg_en;
        acc_wr    = req_ready && req_valid && req_write;
        acc_rd    = req_ready && req_valid && !req_write;
    end
endmodule

// File: rtl/cwm_wrapper.sv
module cwm_wrapper
    import cwm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int N_ENT  = 4,
    localparam int COL_W = (DATA_W > 1) ? $clog2(DATA_W) : 1,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic              cfg_all_rows,
    input  logic [ADDR_W-1:0] cfg_row,
    input  logic [COL_W-1:0]  cfg_col,
    input  logic              cfg_stuck,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              err_unmask,
    output logic              arr_we,
    output logic              arr_re,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W:0]   arr_wdata,
    input  logic [DATA_W:0]   arr_rdata
);
    logic              ent_valid [N_ENT];
    logic              ent_all   [N_ENT];
    logic [ADDR_W-1:0] ent_row   [N_ENT];
    logic [COL_W-1:0]  ent_col   [N_ENT];
    logic              ent_stuck [N_ENT];

    logic       invert, conflict;
    logic       acc_wr, acc_rd;
    cwm_state_e state;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W:0]   word_q;
    logic              err_q;
    logic              rsp_v_q;
    logic [DATA_W-1:0] rsp_d_q;

    cwm_fault_table #(
        .N_ENT(N_ENT), .ADDR_W(ADDR_W), .COL_W(COL_W), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_valid(cfg_valid), .cfg_all_rows(cfg_all_rows),
        .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_stuck(cfg_stuck),
        .ent_valid(ent_valid), .ent_all(ent_all), .ent_row(ent_row),
        .ent_col(ent_col), .ent_stuck(ent_stuck)
    );

    cwm_inv_decide #(
        .N_ENT(N_ENT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)
    ) u_decide (
        .ent_valid(ent_valid), .ent_all(ent_all), .ent_row(ent_row),
        .ent_col(ent_col), .ent_stuck(ent_stuck),
        .addr(req_addr), .wdata(req_wdata),
        .invert(invert), .conflict(conflict)
    );

    cwm_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
        .req_valid(req_valid), .req_write(req_write),
        .state(state), .req_ready(req_ready),
        .acc_wr(acc_wr), .acc_rd(acc_rd)
    );

    // Capture of the decided word and row on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            word_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (acc_wr || acc_rd) addr_q <= req_addr;
            if (acc_wr) begin
                word_q <= invert ? {1'b1, ~req_wdata} : {1'b0, req_wdata};
                if (conflict) err_q <= 1'b1;
            end
        end
    end

    // Read correction stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_v_q <= 1'b0;
            rsp_d_q <= '0;
        end else begin
            rsp_v_q <= (state == S_RXOR);
            if (state == S_RXOR)
                rsp_d_q <= arr_rdata[DATA_W-1:0] ^ {DATA_W{arr_rdata[DATA_W]}};
        end
    end

    always_comb begin
        arr_we     = (state == S_WCOMMIT);
        arr_re     = (state == S_RISSUE);
        arr_addr   = addr_q;
        arr_wdata  = word_q;
        rsp_valid  = rsp_v_q;
        rsp_rdata  = rsp_d_q;
        err_unmask = err_q;
    end
endmodule

// File: rtl/cwm_wrapper_chk.sv
module cwm_wrapper_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_en,
    input logic req_valid,
    input logic req_write,
    input logic req_ready,
    input logic arr_we,
    input logic arr_re,
    input logic rsp_valid,
    input logic err_unmask
);
    a_r8_write_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> arr_we);

    a_r8_read_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> arr_re);

    a_r8_rsp_delay: assert property (@(posedge clk) disable iff (!rst_n)
        arr_re |-> ##2 rsp_valid);

    a_r8_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !arr_we);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_unmask |=> err_unmask);

    a_r9_cfg_stall: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> !req_ready);
endmodule

bind cwm_wrapper cwm_wrapper_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
    .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
    .arr_we(arr_we), .arr_re(arr_re), .rsp_valid(rsp_valid),
    .err_unmask(err_unmask)
);

// File: tb/cwm_wrapper_bench.sv
`timescale 1ns/1ps
module cwm_wrapper_bench;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int NE = 4;
    localparam int CW = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 0, cfg_we = 0, cfg_valid = 0, cfg_all_rows = 0, cfg_stuck = 0;
    logic [IW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_row = '0;
    logic [CW-1:0] cfg_col = '0;
    logic req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, err_unmask, arr_we, arr_re;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] arr_addr;
    logic [DW:0] arr_wdata;
    logic [DW:0] arr_rdata;

    always #2.5 clk = ~clk;

    cwm_wrapper #(.DATA_W(DW), .ADDR_W(AW), .N_ENT(NE)) u_cwm_wrapper (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_all_rows(cfg_all_rows),
        .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_stuck(cfg_stuck),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .err_unmask(err_unmask), .arr_we(arr_we),
        .arr_re(arr_re), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_rdata(arr_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Fault mirror kept by the bench
    bit          fv [NE];
    bit          fa [NE];
    logic [AW-1:0] fr [NE];
    logic [CW-1:0] fc [NE];
    bit          fs [NE];

    logic [DW:0] mem [16];
    logic [DW-1:0] exp_q [$];

    function automatic logic [DW:0] apply_stuck(logic [AW-1:0] a, logic [DW:0] w);
        logic [DW:0] r = w;
        for (int i = 0; i < NE; i++)
            if (fv[i] && (fa[i] || fr[i] == a)) r[fc[i]] = fs[i];
        return r;
    endfunction

    // Storage array model with stuck cells
    always @(posedge clk) begin
        if (arr_we) mem[arr_addr] <= apply_stuck(arr_addr, arr_wdata);
        if (arr_re) arr_rdata <= mem[arr_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read words in order
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected rsp", 32'(rsp_rdata), 32'hffff_ffff);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(rsp_rdata == e, "R5 read data", 32'(rsp_rdata), 32'(e));
            end
        end
    end

    task automatic load(input int idx, input bit v, input bit all, input logic [AW-1:0] row,
                        input logic [CW-1:0] col, input bit stuck, input bit en);
        @(negedge clk);
        cfg_en = en; cfg_we = 1; cfg_idx = IW'(idx); cfg_valid = v;
        cfg_all_rows = all; cfg_row = row; cfg_col = col; cfg_stuck = stuck;
        @(negedge clk);
        cfg_we = 0; cfg_en = 0;
        if (en) begin
            fv[idx] = v; fa[idx] = all; fr[idx] = row; fc[idx] = col; fs[idx] = stuck;
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [DW:0] exp_w, input string req);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        chk(arr_we == 1'b1, "R8 write commit strobe", 32'(arr_we), 32'd1);
        chk(arr_addr == a && arr_wdata == exp_w, req, 32'(arr_wdata), 32'(exp_w));
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        exp_q.push_back(e);
        chk(arr_re == 1'b1 && arr_addr == a, "R8 read issue", 32'(arr_re), 32'd1);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 no early rsp", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        #(5.0 * 20000);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NE; i++) begin fv[i] = 0; fa[i] = 0; fr[i] = '0; fc[i] = '0; fs[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1 && rsp_valid == 0 && err_unmask == 0 && arr_we == 0 && arr_re == 0,
            "R1 reset state", {27'd0, req_ready, rsp_valid, err_unmask, arr_we, arr_re}, 32'h10);

        // R2 no faults: plain RAM
        do_write(4'd3, 16'hA5A5, {1'b0, 16'hA5A5}, "R2 plain write");
        do_read(4'd3, 16'hA5A5);

        // Row-scoped fault: row 5, col 2, stuck 1
        load(0, 1, 0, 4'd5, 4'd2, 1, 1);
        do_write(4'd5, 16'h0004, {1'b0, 16'h0004}, "R3 keep true data");
        do_write(4'd5, 16'h1230, {1'b1, 16'hEDCF}, "R4 complement data");
        do_read(4'd5, 16'h1230);
        do_write(4'd6, 16'h1230, {1'b0, 16'h1230}, "R6 other row unaffected");

        // All-rows fault: col 9, stuck 0
        load(1, 1, 1, 4'd0, 4'd9, 0, 1);
        do_write(4'd7, 16'h0200, {1'b1, 16'hFDFF}, "R6 all-rows entry inverts");
        do_read(4'd7, 16'h0200);
        do_write(4'd5, 16'h0200, {1'b1, 16'hFDFF}, "R4 two entries both invert");
        do_read(4'd5, 16'h0200);

        chk(err_unmask == 0, "R7 no error before conflict", 32'(err_unmask), 32'd0);
        do_write(4'd5, 16'h0000, {1'b0, 16'h0000}, "R7 conflict stores true");
        chk(err_unmask == 1, "R7 error raised", 32'(err_unmask), 32'd1);
        do_read(4'd5, 16'h0004);

        // R10 invalid entry ignored (would force a conflict if valid)
        load(2, 0, 1, 4'd0, 4'd0, 0, 1);
        do_write(4'd2, 16'h0200, {1'b1, 16'hFDFF}, "R10 invalid entry ignored");

        // R9 load outside config window ignored (would force a conflict)
        load(3, 1, 1, 4'd0, 4'd15, 0, 0);
        do_write(4'd1, 16'h0200, {1'b1, 16'hFDFF}, "R9 load without cfg_en ignored");
        chk(err_unmask == 1, "R7 error stays set", 32'(err_unmask), 32'd1);

        // R9 stall while configuring
        @(negedge clk);
        cfg_en = 1; req_valid = 1; req_write = 1; req_addr = 4'd3; req_wdata = 16'h0000;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(req_ready == 0 && arr_we == 0, "R9 stall during cfg", {30'd0, req_ready, arr_we}, 32'd0);
        end
        req_valid = 0; cfg_en = 0;

        // Back-to-back reads through the scoreboard
        do_read(4'd3, 16'hA5A5);
        do_read(4'd7, 16'h0200);
        do_read(4'd6, 16'h1230);
        do_read(4'd2, 16'h0200);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all reads answered", 32'(exp_q.size()), 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule